// File: doc/BRIEF.md
# Profiling Status Register Access Decoder

This block decides what happens when software executes a read or a write that names the privileged profiling-status register. It is purely combinational. Its inputs are:

- the current privilege level (0 to 3) and the access direction;
- which of the two accessor encodings was used: the primary one, or the alias reached through the second opcode group;
- the flags that say whether the profiling feature, level 2, level 3 and fine-grained trapping exist;
- the monitor and hypervisor trap controls, and the fine-grained read and write trap bits;
- the nested-virtualization control bits, the two exception-enable fields and the host-mode status.

The block raises exactly one outcome:

- an undefined-instruction exception;
- a trap to level 2;
- a trap to level 3;
- a redirect to a memory slot at a fixed offset;
- an access to the level-2 variant of the register;
- a plain direct access.

Whenever a trap is raised, the syndrome class of that trap is also driven. Whenever a redirect is raised, the memory offset is also driven. The exception entry and the register storage sit around this block and are not part of it.

Top module: `prof_status_acc_dec`

## Requirements
- R1: With the profiling feature absent, or with the access made at level 0, the outcome is undefined instruction for both accessors.
- R2: For the primary accessor at level 1, the monitor priority check comes first. It holds when level 3 exists, the monitor priority-undefined flag is 1 and the monitor trap condition is 1, and it makes the outcome undefined ahead of every other check.
- R3: For the primary accessor at level 1, the fine-grained trap comes next and gives a trap to level 2. It needs all of the following: level 2 is enabled; the fine-grained feature exists; the level-3 fine-grained enable is 1 or level 3 is absent; and the trap bit of the access direction is 1 (the write bit for writes, the read bit for reads).
- R4: For the primary accessor at level 1, the coarse hypervisor trap comes next. It gives a trap to level 2 when level 2 is enabled and hypervisor control bit 0 is 0.
- R5: The monitor trap (level 3 exists and the monitor trap condition is 1) gives undefined when the monitor undefined-select is 1, and otherwise a trap to level 3.
- R6: The syndrome class output is 0x18 on any trap outcome and 0 otherwise.
- R7: For the primary accessor at level 1, after the checks above, the outcome is a memory redirect when both of these hold:
  - the nested-virtualization bits match 1x1;
  - the level-2 exception-enable field is 00, or the level-1 exception-enable field is 00, or the bits equal 111.

  Otherwise the outcome is a direct access. The offset output is 0x820 on a redirect and 0 otherwise.
- R8: For the primary accessor at level 2, once the monitor checks have not fired, the outcome is the level-2 variant register when the level-2 exception-enable field is nonzero and host mode is 1. Otherwise it is a direct access.
- R9: For the primary accessor at level 3, the outcome is always a direct access.
- R10: For the alias accessor at level 1, the outcome depends only on the nested-virtualization bits:
  - a memory redirect when they equal 101;
  - otherwise a trap to level 2 when bit 0 is 1;
  - otherwise undefined.
- R11: For the alias accessor at levels 2 and 3, the outcome is undefined unless host mode is 1. With host mode at 1:
  - level 2 applies the monitor checks, then gives a direct access;
  - level 3 gives a direct access.
- R12: For every input combination, exactly one of the six outcome outputs is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_lvl | input | 2 | Current privilege level |
| is_write | input | 1 | 1 for a write, 0 for a read |
| alias_acc | input | 1 | 1 when the alias accessor encoding was used |
| prof_ok | input | 1 | Profiling feature present |
| fg_feat | input | 1 | Fine-grained trap feature present |
| l2_on | input | 1 | Level 2 enabled for the current state |
| l3_have | input | 1 | Level 3 implemented |
| mon_prio | input | 1 | Monitor priority-undefined flag |
| mon_trap | input | 1 | Monitor trap condition for this register |
| mon_undef | input | 1 | Monitor undefined-select |
| fg_l3_en | input | 1 | Level-3 enable for fine-grained traps |
| fg_rd_bit | input | 1 | Fine-grained read-trap bit |
| fg_wr_bit | input | 1 | Fine-grained write-trap bit |
| hyp_ctl_b0 | input | 1 | Hypervisor buffer control bit 0 |
| nv_bits | input | 3 | Nested-virtualization control bits |
| l2_ee | input | 2 | Effective level-2 exception-enable field |
| l1_ee | input | 2 | Level-1 exception-enable field |
| host_mode | input | 1 | Level 2 running in host mode |
| o_undef | output | 1 | Undefined instruction |
| o_trap_l2 | output | 1 | Trap to level 2 |
| o_trap_l3 | output | 1 | Trap to level 3 |
| o_mem_redirect | output | 1 | Redirect to the memory slot |
| o_l2_variant | output | 1 | Access goes to the level-2 variant register |
| o_direct | output | 1 | Direct access |
| o_syn_class | output | 6 | Trap syndrome class |
| o_mem_offset | output | 12 | Memory slot offset |

## Verification
The bench builds the block with its default parameters: a 6-bit syndrome class of 0x18 and a 12-bit offset of 0x820. Since no parameter changes the decision logic, the sweep concentrates on the input space instead.

Every combination of the following inputs is enumerated exhaustively: level, direction, accessor, feature-present, host mode and all eight nested-virtualization codes. For each of these, a spread of patterns over the remaining monitor, hypervisor, fine-grained and exception-enable inputs is applied. This reaches every step of both ordered chains, including the cases where two or more checks are true at once and only their priority decides the outcome.

// File: rtl/prof_acc_pkg.sv
package prof_acc_pkg;

  typedef enum logic [2:0] {
    OC_UNDEF   = 3'd0,
    OC_TRAP_L2 = 3'd1,
    OC_TRAP_L3 = 3'd2,
    OC_MEM     = 3'd3,
    OC_L2REG   = 3'd4,
    OC_DIRECT  = 3'd5
  } outcome_e;

  localparam int unsigned NUM_OC = 6;

  typedef struct packed {
    logic [1:0] lvl;
    logic       is_wr;
    logic       fg_feat;
    logic       l2_on;
    logic       l3_have;
    logic       fg_l3_en;
    logic       fg_rd;
    logic       fg_wr;
    logic       hyp_b0;
    logic [2:0] nv;
    logic [1:0] l2_ee;
    logic [1:0] l1_ee;
    logic       host;
  } main_ctx_t;

endpackage

// File: rtl/prof_acc_mon_gate.sv
module prof_acc_mon_gate (
  input  logic l3_have,
  input  logic mon_prio,
  input  logic mon_trap,
  output logic prio_undef,
  output logic mon_hit
);
  // Monitor trap only exists when level 3 is implemented.
  always_comb begin
    mon_hit    = l3_have & mon_trap;
    prio_undef = l3_have & mon_trap & mon_prio;
  end
endmodule

// File: rtl/prof_acc_main_chain.sv
module prof_acc_main_chain
  import prof_acc_pkg::*;
(
  input  main_ctx_t ctx,
  input  logic      prio_undef,
  input  logic      mon_hit,
  input  logic      mon_undef,
  output outcome_e  oc
);
  logic fg_hit;
  logic hyp_hit;
  logic nv_hit;
  logic mon_oc_undef;

  always_comb begin
    fg_hit = ctx.l2_on & ctx.fg_feat & (ctx.fg_l3_en | ~ctx.l3_have)
           & (ctx.is_wr ? ctx.fg_wr : ctx.fg_rd);
    hyp_hit = ctx.l2_on & ~ctx.hyp_b0;
    nv_hit  = ctx.nv[2] & ctx.nv[0]
            & ((ctx.l2_ee == 2'b00) | (ctx.l1_ee == 2'b00) | ctx.nv[1]);
    mon_oc_undef = mon_undef;
  end

  always_comb begin
    oc = OC_UNDEF;
    unique case (ctx.lvl)
      2'd1: begin
        if (prio_undef)   oc = OC_UNDEF;
        else if (fg_hit)  oc = OC_TRAP_L2;
        else if (hyp_hit) oc = OC_TRAP_L2;
        else if (mon_hit) oc = mon_oc_undef ? OC_UNDEF : OC_TRAP_L3;
        else if (nv_hit)  oc = OC_MEM;
        else              oc = OC_DIRECT;
      end
      2'd2: begin
        if (prio_undef)   oc = OC_UNDEF;
        else if (mon_hit) oc = mon_oc_undef ? OC_UNDEF : OC_TRAP_L3;
        else if ((ctx.l2_ee != 2'b00) && ctx.host) oc = OC_L2REG;
        else              oc = OC_DIRECT;
      end
      2'd3:    oc = OC_DIRECT;
      default: oc = OC_UNDEF;
    endcase
  end
endmodule

// File: rtl/prof_acc_alias_chain.sv
module prof_acc_alias_chain
  import prof_acc_pkg::*;
(
  input  logic [1:0] lvl,
  input  logic [2:0] nv,
  input  logic       host,
  input  logic       prio_undef,
  input  logic       mon_hit,
  input  logic       mon_undef,
  output outcome_e   oc
);
  always_comb begin
    oc = OC_UNDEF;
    unique case (lvl)
      2'd1: begin
        if (nv == 3'b101) oc = OC_MEM;
        else if (nv[0])   oc = OC_TRAP_L2;
        else              oc = OC_UNDEF;
      end
      2'd2: begin
        if (!host)           oc = OC_UNDEF;
        else if (prio_undef) oc = OC_UNDEF;
        else if (mon_hit)    oc = mon_undef ? OC_UNDEF : OC_TRAP_L3;
        else                 oc = OC_DIRECT;
      end
      2'd3:    oc = host ? OC_DIRECT : OC_UNDEF;
      default: oc = OC_UNDEF;
    endcase
  end
endmodule

// File: rtl/prof_status_acc_dec.sv
module prof_status_acc_dec
  import prof_acc_pkg::*;
#(
  parameter int unsigned        CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
  parameter int unsigned        OFFS_W     = 12,
  parameter logic [OFFS_W-1:0]  MEM_OFFSET = 12'h820
) (
  input  logic [1:0]         cur_lvl,
  input  logic               is_write,
  input  logic               alias_acc,
  input  logic               prof_ok,
  input  logic               fg_feat,
  input  logic               l2_on,
  input  logic               l3_have,
  input  logic               mon_prio,
  input  logic               mon_trap,
  input  logic               mon_undef,
  input  logic               fg_l3_en,
  input  logic               fg_rd_bit,
  input  logic               fg_wr_bit,
  input  logic               hyp_ctl_b0,
  input  logic [2:0]         nv_bits,
  input  logic [1:0]         l2_ee,
  input  logic [1:0]         l1_ee,
  input  logic               host_mode,
  output logic               o_undef,
  output logic               o_trap_l2,
  output logic               o_trap_l3,
  output logic               o_mem_redirect,
  output logic               o_l2_variant,
  output logic               o_direct,
  output logic [CLASS_W-1:0] o_syn_class,
  output logic [OFFS_W-1:0]  o_mem_offset
);
  main_ctx_t          ctx;
  logic               prio_undef;
  logic               mon_hit;
  outcome_e           main_oc;
  outcome_e           alias_oc;
  outcome_e           sel_oc;
  logic [NUM_OC-1:0]  oc_vec;

  always_comb begin
    ctx.lvl      = cur_lvl;
    ctx.is_wr    = is_write;
    ctx.fg_feat  = fg_feat;
    ctx.l2_on    = l2_on;
    ctx.l3_have  = l3_have;
    ctx.fg_l3_en = fg_l3_en;
    ctx.fg_rd    = fg_rd_bit;
    ctx.fg_wr    = fg_wr_bit;
    ctx.hyp_b0   = hyp_ctl_b0;
    ctx.nv       = nv_bits;
    ctx.l2_ee    = l2_ee;
    ctx.l1_ee    = l1_ee;
    ctx.host     = host_mode;
  end

  prof_acc_mon_gate mon_i (
    .l3_have    (l3_have),
    .mon_prio   (mon_prio),
    .mon_trap   (mon_trap),
    .prio_undef (prio_undef),
    .mon_hit    (mon_hit)
  );

  prof_acc_main_chain main_i (
    .ctx        (ctx),
    .prio_undef (prio_undef),
    .mon_hit    (mon_hit),
    .mon_undef  (mon_undef),
    .oc         (main_oc)
  );

  prof_acc_alias_chain alias_i (
    .lvl        (cur_lvl),
    .nv         (nv_bits),
    .host       (host_mode),
    .prio_undef (prio_undef),
    .mon_hit    (mon_hit),
    .mon_undef  (mon_undef),
    .oc         (alias_oc)
  );

  // Feature absence and level 0 override both chains.
  always_comb begin
    if (!prof_ok || (cur_lvl == 2'd0)) sel_oc = OC_UNDEF;
    else if (alias_acc)                sel_oc = alias_oc;
    else                               sel_oc = main_oc;
  end

  for (genvar g = 0; g < NUM_OC; g++) begin : g_onehot
    assign oc_vec[g] = (sel_oc == outcome_e'(g));
  end

  assign o_undef        = oc_vec[OC_UNDEF];
  assign o_trap_l2      = oc_vec[OC_TRAP_L2];
  assign o_trap_l3      = oc_vec[OC_TRAP_L3];
  assign o_mem_redirect = oc_vec[OC_MEM];
  assign o_l2_variant   = oc_vec[OC_L2REG];
  assign o_direct       = oc_vec[OC_DIRECT];
  assign o_syn_class    = (oc_vec[OC_TRAP_L2] | oc_vec[OC_TRAP_L3]) ? TRAP_CLASS : '0;
  assign o_mem_offset   = oc_vec[OC_MEM] ? MEM_OFFSET : '0;
endmodule

// File: rtl/prof_status_acc_chk.sv
module prof_status_acc_chk #(
  parameter int unsigned        CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
  parameter int unsigned        OFFS_W     = 12,
  parameter logic [OFFS_W-1:0]  MEM_OFFSET = 12'h820
) (
  input logic [1:0]         cur_lvl,
  input logic               alias_acc,
  input logic               prof_ok,
  input logic               host_mode,
  input logic               o_undef,
  input logic               o_trap_l2,
  input logic               o_trap_l3,
  input logic               o_mem_redirect,
  input logic               o_l2_variant,
  input logic               o_direct,
  input logic [CLASS_W-1:0] o_syn_class,
  input logic [OFFS_W-1:0]  o_mem_offset
);
  always_comb begin
    // R12
    one_outcome_chk: assert ($onehot({o_undef, o_trap_l2, o_trap_l3,
                                      o_mem_redirect, o_l2_variant, o_direct}));
    // R6
    trap_class_chk: assert ((o_trap_l2 || o_trap_l3) ? (o_syn_class == TRAP_CLASS)
                                                     : (o_syn_class == '0));
    // R7
    mem_offset_chk: assert (o_mem_redirect ? (o_mem_offset == MEM_OFFSET)
                                           : (o_mem_offset == '0));
    // R1
    absent_undef_chk: assert (!(!prof_ok || cur_lvl == 2'd0) || o_undef);
    // R9
    top_level_direct_chk: assert (!(prof_ok && !alias_acc && cur_lvl == 2'd3) || o_direct);
    // R11
    alias_guest_undef_chk: assert (!(prof_ok && alias_acc && cur_lvl[1] && !host_mode)
                                   || o_undef);
  end
endmodule

bind prof_status_acc_dec prof_status_acc_chk #(
  .CLASS_W(CLASS_W), .TRAP_CLASS(TRAP_CLASS), .OFFS_W(OFFS_W), .MEM_OFFSET(MEM_OFFSET)
) chk_i (
  .cur_lvl(cur_lvl), .alias_acc(alias_acc), .prof_ok(prof_ok), .host_mode(host_mode),
  .o_undef(o_undef), .o_trap_l2(o_trap_l2), .o_trap_l3(o_trap_l3),
  .o_mem_redirect(o_mem_redirect), .o_l2_variant(o_l2_variant), .o_direct(o_direct),
  .o_syn_class(o_syn_class), .o_mem_offset(o_mem_offset)
);

// File: tb/prof_status_acc_dec_tb_top.sv
module prof_status_acc_dec_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] cur_lvl;
  logic       is_write, alias_acc, prof_ok, fg_feat, l2_on, l3_have;
  logic       mon_prio, mon_trap, mon_undef, fg_l3_en, fg_rd_bit, fg_wr_bit;
  logic       hyp_ctl_b0, host_mode;
  logic [2:0] nv_bits;
  logic [1:0] l2_ee, l1_ee;
  logic       o_undef, o_trap_l2, o_trap_l3, o_mem_redirect, o_l2_variant, o_direct;
  logic [5:0] o_syn_class;
  logic [11:0] o_mem_offset;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  prof_status_acc_dec dut_i (.*);

  // outcome codes: 0 undef, 1 trap L2, 2 trap L3, 3 mem, 4 L2 variant, 5 direct
  function automatic void ref_model(output int oc, output string tag);
    bit prio_u, mon_h, fg_h, hyp_h, nv_h;
    mon_h  = l3_have && mon_trap;
    prio_u = mon_h && mon_prio;
    fg_h   = l2_on && fg_feat && (fg_l3_en || !l3_have) && (is_write ? fg_wr_bit : fg_rd_bit);
    hyp_h  = l2_on && !hyp_ctl_b0;
    nv_h   = (nv_bits == 3'b101 || nv_bits == 3'b111)
             && (l2_ee == 0 || l1_ee == 0 || nv_bits == 3'b111);
    if (!prof_ok || cur_lvl == 0) begin oc = 0; tag = "R1"; end
    else if (!alias_acc) begin
      if (cur_lvl == 1) begin
        if (prio_u)      begin oc = 0; tag = "R2"; end
        else if (fg_h)   begin oc = 1; tag = "R3"; end
        else if (hyp_h)  begin oc = 1; tag = "R4"; end
        else if (mon_h)  begin oc = mon_undef ? 0 : 2; tag = "R5"; end
        else if (nv_h)   begin oc = 3; tag = "R7"; end
        else             begin oc = 5; tag = "R7"; end
      end else if (cur_lvl == 2) begin
        if (prio_u)      begin oc = 0; tag = "R5"; end
        else if (mon_h)  begin oc = mon_undef ? 0 : 2; tag = "R5"; end
        else             begin oc = (l2_ee != 0 && host_mode) ? 4 : 5; tag = "R8"; end
      end else begin oc = 5; tag = "R9"; end
    end else begin
      if (cur_lvl == 1) begin
        tag = "R10";
        oc = (nv_bits == 3'b101) ? 3 : (nv_bits[0] ? 1 : 0);
      end else begin
        tag = "R11";
        if (!host_mode)                  oc = 0;
        else if (cur_lvl == 3)           oc = 5;
        else if (prio_u)                 oc = 0;
        else if (mon_h)                  oc = mon_undef ? 0 : 2;
        else                             oc = 5;
      end
    end
  endfunction

  task automatic check_now();
    int    exp_oc;
    string tag;
    logic [5:0] got_vec, exp_vec;
    ref_model(exp_oc, tag);
    exp_vec = 6'b1 << exp_oc;
    got_vec = {o_direct, o_l2_variant, o_mem_redirect, o_trap_l3, o_trap_l2, o_undef};
    total++;
    if (got_vec != exp_vec) begin
      bad++;
      $display("FAIL %s (R12 outcome) lvl=%0d alias=%0b nv=%b: got %b exp %b",
               tag, cur_lvl, alias_acc, nv_bits, got_vec, exp_vec);
    end
    total++;
    if (o_syn_class != ((exp_oc == 1 || exp_oc == 2) ? 6'h18 : 6'h00)) begin
      bad++;
      $display("FAIL R6 class: got %h exp %h", o_syn_class,
               (exp_oc == 1 || exp_oc == 2) ? 6'h18 : 6'h00);
    end
    total++;
    if (o_mem_offset != ((exp_oc == 3) ? 12'h820 : 12'h000)) begin
      bad++;
      $display("FAIL R7 offset: got %h exp %h", o_mem_offset,
               (exp_oc == 3) ? 12'h820 : 12'h000);
    end
  endtask

  initial begin
    {cur_lvl, is_write, alias_acc, prof_ok, fg_feat, l2_on, l3_have, mon_prio, mon_trap,
     mon_undef, fg_l3_en, fg_rd_bit, fg_wr_bit, hyp_ctl_b0, nv_bits, l2_ee, l1_ee,
     host_mode} = '0;
    @(negedge clk);
    #2;
    // R1: all-zero inputs give undefined
    check_now();
    for (int s = 0; s < 512; s++) begin
      for (int k = 0; k < 48; k++) begin
        logic [13:0] r;
        @(negedge clk);
        {cur_lvl, is_write, alias_acc, prof_ok, host_mode, nv_bits} = 9'(s);
        prof_ok = prof_ok | (k != 0);
        r = 14'($urandom);
        {fg_feat, l2_on, l3_have, mon_prio, mon_trap, mon_undef, fg_l3_en,
         fg_rd_bit, fg_wr_bit, hyp_ctl_b0, l2_ee, l1_ee} = r;
        #2;
        check_now();
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule